// File: doc/BRIEF.md
# Single-Channel Block Copy Engine with Status Byte

This block copies a contiguous region of memory to another contiguous region, one beat at a time. Each beat is a read from the source address followed by a write of the same data to the destination address. The width of a beat is chosen per transfer: 1, 2, 4 or 16 bytes. Software sets up the source address, the destination address, the byte count and the beat size on plain input pins, then pulses `start`. The engine checks the setup at that moment. If the setup is unusable, the engine flags it and moves nothing.

Progress and outcome are shown in a byte-wide status word that is always visible on `reg_rdata`. The status word is cleared through a one-bit write strobe. The engine only issues bus requests while its channel is selected by an outside arbiter (`chan_sel`). While the channel has work but is not selected, a request-pending flag is shown.

The memory side is a valid/ready master. A request is offered with `bus_valid` and is accepted in the cycle where `bus_ready` is also high. The slave returns read data on `bus_rdata` in that same cycle, and an error flag on `bus_err`. The slave may hold `bus_ready` low for any number of cycles. Once `bus_valid` is high, address, direction, size and write data stay frozen until the handshake completes, even if the channel loses selection in the meantime. A new request is raised only while `chan_sel` is high.

Top module: `dma_chan_stat`

## Requirements
- R1: After reset the status byte is 0x00. Bits 7 and 3 always read 0. The layout is bit 6 setup error, bit 5 read-side bus error, bit 4 write-side bus error, bit 2 request pending, bit 1 busy, bit 0 done.
- R2: Size code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 16 bytes. A start whose byte count is not a multiple of the beat size sets bit 6 and issues no bus request.
- R3: A start with a byte count of 0 sets bit 6 and issues no bus request.
- R4: A start whose source or destination address is not a multiple of the beat size sets bit 6 and issues no bus request.
- R5: An accepted start sets busy. Each beat reads from the source and then writes the data just read to the destination. After each successful write, both addresses advance by the beat size. When the count is used up, busy drops and done is set.
- R6: An error on a read handshake stops the channel at once. It sets bits 5 and 0 and clears busy.
- R7: An error on a write handshake stops the channel at once. It sets bits 4 and 0 and clears busy.
- R8: Bit 2 is 1 exactly when the channel is busy and `chan_sel` is low. No new bus request is raised while `chan_sel` is low.
- R9: Writing a byte with bit 0 set clears bits 6, 5, 4 and 0. Writes with bit 0 clear change nothing.
- R10: A start that arrives while busy is ignored. It does not alter the transfer in flight and does not set bit 6.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_addr | input | AW | Source start address, sampled on start |
| dst_addr | input | AW | Destination start address, sampled on start |
| byte_cnt | input | CW | Bytes to move, sampled on start |
| xfer_size | input | 2 | Beat size code (see R2) |
| start | input | 1 | One-cycle start pulse |
| chan_sel | input | 1 | Channel granted the bus |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Status write data |
| reg_rdata | output | 8 | Status byte |
| bus_valid | output | 1 | Request valid |
| bus_ready | input | 1 | Request accepted and completed |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Request address |
| bus_size | output | 2 | Beat size code of the request |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid at handshake |
| bus_err | input | 1 | Error response, valid at handshake |

## Verification
The bench targets the boundary cases of the setup check: counts that fall one byte short of a multiple, a zero count, and addresses that are misaligned on only one side. A checker that tested only the count would start a transfer that should have been refused. A checker that ignored alignment would issue a bus request that should never appear.

Errors are injected on the first and later beats, on both the read and the write side. An engine that swapped the two error flags, or kept going after an error, would report the wrong bits or produce extra handshakes.

Random selection and back-pressure are applied throughout. An engine that dropped a held request, let its address drift, or showed the request-pending flag while selected would be caught. A second start pulse in mid-transfer, carrying a junk setup, exposes any engine that reloads or flags that setup.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int STAT_W = 8;
  localparam int B_DONE = 0;
  localparam int B_BUSY = 1;
  localparam int B_REQ  = 2;
  localparam int B_BED  = 4;
  localparam int B_BES  = 5;
  localparam int B_CE   = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LINE = 2'd3
  } xfer_sz_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RD   = 2'd1,
    PH_WR   = 2'd2
  } phase_e;

  function automatic logic [4:0] beat_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: beat_bytes = 5'd1;
      SZ_WORD: beat_bytes = 5'd2;
      SZ_LONG: beat_bytes = 5'd4;
      default: beat_bytes = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic [1:0]    size,
  output logic          bad
);
  // the low nibble carries every alignment the largest beat needs
  localparam int LOWB = 4;

  logic [4:0]      span;
  logic [LOWB-1:0] mask;
  logic            cnt_zero, cnt_odd, src_odd, dst_odd;

  always_comb begin
    span     = beat_bytes(size);
    mask     = span[LOWB-1:0] - 4'd1;
    cnt_zero = (cnt == '0);
    cnt_odd  = |(cnt[LOWB-1:0] & mask);
    src_odd  = |(src[LOWB-1:0] & mask);
    dst_odd  = |(dst[LOWB-1:0] & mask);
    bad      = cnt_zero | cnt_odd | src_odd | dst_odd;
  end
endmodule

// File: rtl/dma_xfer_eng.sv
module dma_xfer_eng
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic [1:0]    ld_size,
  input  logic          chan_sel,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err,
  output logic          busy,
  output logic          ev_done,
  output logic          ev_rd_err,
  output logic          ev_wr_err
);
  phase_e        ph_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    size_q;
  logic [DW-1:0] hold_q;
  logic          stuck_q;

  logic [AW-1:0] step_a;
  logic [CW-1:0] step_c;
  logic          hs, last;

  always_comb begin
    step_a    = AW'(beat_bytes(size_q));
    step_c    = CW'(beat_bytes(size_q));
    busy      = (ph_q != PH_IDLE);
    bus_valid = busy & (chan_sel | stuck_q);
    bus_write = (ph_q == PH_WR);
    bus_addr  = bus_write ? dst_q : src_q;
    bus_size  = size_q;
    bus_wdata = hold_q;
    hs        = bus_valid & bus_ready;
    last      = (cnt_q == step_c);
    ev_rd_err = hs & (ph_q == PH_RD) & bus_err;
    ev_wr_err = hs & (ph_q == PH_WR) & bus_err;
    ev_done   = hs & (ph_q == PH_WR) & ~bus_err & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      size_q  <= SZ_BYTE;
      hold_q  <= '0;
      stuck_q <= 1'b0;
    end else begin
      stuck_q <= bus_valid & ~bus_ready;
      case (ph_q)
        PH_IDLE: begin
          if (go) begin
            src_q  <= ld_src;
            dst_q  <= ld_dst;
            cnt_q  <= ld_cnt;
            size_q <= ld_size;
            ph_q   <= PH_RD;
          end
        end
        PH_RD: begin
          if (hs) begin
            if (bus_err) begin
              ph_q <= PH_IDLE;
            end else begin
              hold_q <= bus_rdata;
              ph_q   <= PH_WR;
            end
          end
        end
        PH_WR: begin
          if (hs) begin
            if (bus_err) begin
              ph_q <= PH_IDLE;
            end else begin
              cnt_q <= cnt_q - step_c;
              src_q <= src_q + step_a;
              dst_q <= dst_q + step_a;
              ph_q  <= last ? PH_IDLE : PH_RD;
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ce,
  input  logic              set_bes,
  input  logic              set_bed,
  input  logic              set_done,
  input  logic              busy,
  input  logic              chan_sel,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat
);
  localparam int NFLAG = 4;
  localparam int POS [NFLAG] = '{B_DONE, B_BED, B_BES, B_CE};

  logic [NFLAG-1:0] setv, flag_q;
  logic             wipe;

  assign setv = {set_ce, set_bes, set_bed, set_done};
  assign wipe = wr_en & wr_data[B_DONE];

  // a set event in the same cycle as a wipe wins
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q[i] <= 1'b0;
      else if (setv[i]) flag_q[i] <= 1'b1;
      else if (wipe)    flag_q[i] <= 1'b0;
    end
  end

  always_comb begin
    stat         = '0;
    stat[B_DONE] = flag_q[0];
    stat[B_BED]  = flag_q[1];
    stat[B_BES]  = flag_q[2];
    stat[B_CE]   = flag_q[3];
    stat[B_BUSY] = busy;
    stat[B_REQ]  = busy & ~chan_sel;
  end

  initial begin
    if (POS[0] != B_DONE) $error("flag order");
  end
endmodule

// File: rtl/dma_chan_stat.sv
module dma_chan_stat
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic [1:0]    xfer_size,
  input  logic          start,
  input  logic          chan_sel,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err
);
  logic cfg_bad, busy, go, refuse;
  logic ev_done, ev_rd_err, ev_wr_err;

  assign go     = start & ~busy & ~cfg_bad;
  assign refuse = start & ~busy & cfg_bad;

  dma_cfg_check #(.AW(AW), .CW(CW)) u_chk_cfg (
    .src  (src_addr),
    .dst  (dst_addr),
    .cnt  (byte_cnt),
    .size (xfer_size),
    .bad  (cfg_bad)
  );

  dma_xfer_eng #(.AW(AW), .CW(CW), .DW(DW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .ld_src    (src_addr),
    .ld_dst    (dst_addr),
    .ld_cnt    (byte_cnt),
    .ld_size   (xfer_size),
    .chan_sel  (chan_sel),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .busy      (busy),
    .ev_done   (ev_done),
    .ev_rd_err (ev_rd_err),
    .ev_wr_err (ev_wr_err)
  );

  dma_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ce   (refuse),
    .set_bes  (ev_rd_err),
    .set_bed  (ev_wr_err),
    .set_done (ev_done | ev_rd_err | ev_wr_err),
    .busy     (busy),
    .chan_sel (chan_sel),
    .wr_en    (reg_wr),
    .wr_data  (reg_wdata),
    .stat     (reg_rdata)
  );
endmodule

// File: rtl/dma_chan_stat_chk.sv
module dma_chan_stat_chk #(
  parameter int AW = 32,
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          chan_sel,
  input logic          reg_wr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_err
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0 && reg_rdata[3] == 1'b0);

  p_bus_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> reg_rdata[1]);

  p_rd_err_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_err && !bus_write
      |=> reg_rdata[5] && reg_rdata[0] && !reg_rdata[1]);

  p_wr_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_err && bus_write
      |=> reg_rdata[4] && reg_rdata[0] && !reg_rdata[1]);

  p_sel_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sel |-> !reg_rdata[2]);

  p_new_req_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> chan_sel);

  p_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[0] && !reg_rdata[1] && !start
      |=> reg_rdata[6:4] == 3'b000 && !reg_rdata[0]);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready
      |=> bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata));
endmodule

bind dma_chan_stat dma_chan_stat_chk #(.AW(AW), .DW(DW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .chan_sel  (chan_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err)
);

// File: tb/sim_dma_chan_stat.sv
module sim_dma_chan_stat;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [1:0]    xfer_size = '0;
  logic          start = 1'b0, chan_sel = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          bus_valid, bus_write;
  logic          bus_ready = 1'b0, bus_err = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int nchk = 0;
  int nbad = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    pat = {a ^ 32'hDEAD_0000, ~a, {a[15:0], a[31:16]}, a + 32'h77};
  endfunction

  function automatic int szb(input logic [1:0] s);
    szb = (s == 2'd3) ? 16 : (1 << s);
  endfunction

  function automatic bit refused(input logic [AW-1:0] s, input logic [AW-1:0] d,
                                 input logic [CW-1:0] c, input logic [1:0] z);
    int m;
    m = szb(z) - 1;
    refused = (c == 0) || ((int'(c) & m) != 0) || ((int'(s[7:0]) & m) != 0)
              || ((int'(d[7:0]) & m) != 0);
  endfunction

  assign bus_rdata = pat(bus_addr);

  dma_chan_stat #(.AW(AW), .CW(CW), .DW(DW)) u0 (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wipe();
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'hFE;
    @(negedge clk);
    reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    #1 chk("R9 wipe", DW'(reg_rdata), DW'(8'h00));
  endtask

  // err_at: handshake index that gets an error, -1 for none
  task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] d,
                     input logic [CW-1:0] c, input logic [1:0] z,
                     input int err_at, input int sel_pct, input int rdy_pct,
                     input bit poke);
    int total, k, guard, sb;
    bit stop, saw;
    logic [AW-1:0] es, ed;
    logic [7:0] expst;
    @(negedge clk);
    src_addr = s; dst_addr = d; byte_cnt = c; xfer_size = z; start = 1'b1;
    chan_sel = 1'b0; bus_ready = 1'b0; bus_err = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (refused(s, d, c, z)) begin
      saw = 1'b0;
      for (int i = 0; i < 3; i++) begin
        chan_sel = 1'b1; bus_ready = 1'b1;
        #1 if (bus_valid) saw = 1'b1;
        @(negedge clk);
      end
      bus_ready = 1'b0;
      chk("R2 R3 R4 no bus on refused start", DW'(saw), DW'(0));
      chk("R2 R3 R4 setup error flag", DW'(reg_rdata), DW'(8'h40));
      wipe();
      return;
    end
    sb = szb(z);
    total = 2 * (int'(c) / sb);
    k = 0; guard = 0; stop = 1'b0; es = s; ed = d;
    while (k < total && !stop && guard < 20000) begin
      if (guard > 0) @(negedge clk);
      guard++;
      chan_sel  = ($urandom % 100) < sel_pct;
      bus_ready = ($urandom % 100) < rdy_pct;
      bus_err   = (k == err_at);
      if (poke && k == 2) begin
        start = 1'b1; byte_cnt = 16'd3; src_addr = 32'h1; dst_addr = 32'h3;
      end else begin
        start = 1'b0;
      end
      #1;
      chk("R8 request pending flag", DW'(reg_rdata[2:1]), DW'({~chan_sel, 1'b1}));
      if (bus_valid && bus_ready) begin
        if (k % 2 == 0) begin
          chk("R5 read address", DW'({bus_write, bus_addr}), DW'({1'b0, es}));
        end else begin
          chk("R5 write address", DW'({bus_write, bus_addr}), DW'({1'b1, ed}));
          chk("R5 write data", bus_wdata, pat(es));
          es = es + AW'(sb); ed = ed + AW'(sb);
        end
        if (k == err_at) stop = 1'b1;
        k++;
      end
    end
    @(negedge clk);
    bus_ready = 1'b0; bus_err = 1'b0; start = 1'b0;
    expst = 8'h01;
    if (stop) expst = (err_at % 2 == 0) ? 8'h21 : 8'h11;
    #1 chk(stop ? ((err_at % 2 == 0) ? "R6 read error end" : "R7 write error end")
                : (poke ? "R10 late start ignored" : "R5 completion"),
           DW'(reg_rdata), DW'(expst));
    wipe();
  endtask

  initial begin
    #(8 * 150000);
    nbad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset status", DW'({reg_rdata, bus_valid}), DW'(9'h000));
    // directed cases
    run(32'h1000, 32'h2000, 16'd64, 2'd3, -1, 100, 100, 1'b0);
    run(32'h0103, 32'h0207, 16'd5,  2'd0, -1, 70, 60, 1'b0);
    run(32'h1000, 32'h2000, 16'd3,  2'd1, -1, 100, 100, 1'b0);  // R2
    run(32'h1000, 32'h2000, 16'd60, 2'd3, -1, 100, 100, 1'b0);  // R2
    run(32'h1000, 32'h2000, 16'd0,  2'd2, -1, 100, 100, 1'b0);  // R3
    run(32'h1002, 32'h2000, 16'd8,  2'd2, -1, 100, 100, 1'b0);  // R4
    run(32'h1000, 32'h2008, 16'd32, 2'd3, -1, 100, 100, 1'b0);  // R4
    run(32'h3000, 32'h4000, 16'd16, 2'd2, 0,  100, 100, 1'b0);  // R6
    run(32'h3000, 32'h4000, 16'd16, 2'd2, 2,  80, 70, 1'b0);    // R6
    run(32'h3000, 32'h4000, 16'd16, 2'd1, 3,  80, 70, 1'b0);    // R7
    run(32'h5000, 32'h6000, 16'd32, 2'd2, -1, 90, 90, 1'b1);    // R10
    run(32'h7000, 32'h8000, 16'd48, 2'd3, -1, 30, 30, 1'b0);    // R8 R11
    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [1:0] z;
      int sb, n, ea;
      logic [AW-1:0] s, d;
      logic [CW-1:0] c;
      z  = 2'($urandom % 4);
      sb = szb(z);
      n  = 1 + ($urandom % 6);
      c  = CW'(n * sb + ((($urandom % 8) == 0) ? 1 : 0));
      s  = ($urandom & 32'h0000_FFF0) | ((($urandom % 6) == 0) ? 32'h2 : 32'h0);
      d  = ($urandom & 32'h0001_FFF0) | 32'h1_0000;
      ea = (($urandom % 4) == 0) ? int'($urandom % (2 * n)) : -1;
      run(s, d, c, z, ea, 40 + int'($urandom % 61), 30 + int'($urandom % 71), 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule